// File: doc/BRIEF.md
# Host Link Power Management Sequencer

This block sequences the host side of a link power management exchange. Software writes a one to a transmit control bit. The sequencer then asks the packet engine to send the low-power transaction. It watches the replies: the first reply token ends the attempt, and each silent timeout triggers another attempt until a fixed number of timeouts has been reached. The transmit bit is shown as a busy flag and drops by itself when the attempt ends.

A second control bit starts resume signalling that takes the link out of the sleep state. The drive length is a programmable duration field multiplied by a fixed step of microsecond ticks. The field is captured when the resume starts. The resume bit clears when the timed signalling ends. A transmit request that arrives while resume is being driven is held and launched on the cycle the resume ends.

Top module: `lpm_host_seq`

## Requirements
- R1: While `rst` is high at a clock edge, and after that edge, `lpm_req`, `xmit_busy`, `xmit_held` and `resume_drv` are all 0, and the timeout count is zero.
- R2: A `xmit_wr` pulse while idle and with no resume active sets `xmit_busy` at the next edge and raises `lpm_req` for exactly that one cycle.
- R3: While busy, the first and second `timeout_evt` each raise `lpm_req` again for one cycle at the next edge, and `xmit_busy` stays 1.
- R4: The third `timeout_evt` of one attempt clears `xmit_busy` at the next edge without a further `lpm_req` (MAX_TIMEOUTS = 3 by default).
- R5: A `token_rx` while busy clears `xmit_busy` at the next edge. When it comes in the same cycle as `timeout_evt`, the token wins and there is no retry pulse.
- R6: Each new launch and each token resets the timeout count, so a fresh attempt again allows two retries before it gives up.
- R7: `xmit_wr` while busy, and `token_rx` or `timeout_evt` while idle, leave `lpm_req` and `xmit_busy` unchanged.
- R8: A `resume_wr` pulse while resume is idle raises `resume_drv` at the next edge. It stays high for exactly (D+1)*STEP_TICKS cycles that carry `us_tick`, where D is `resume_dur` at the start edge, and then clears by itself. Cycles without `us_tick` do not advance the count.
- R9: Changing `resume_dur`, or pulsing `resume_wr`, while `resume_drv` is high does not change the length of the current resume.
- R10: A `xmit_wr` while idle but during resume sets `xmit_held` and leaves `xmit_busy` at 0. On the edge where `resume_drv` falls, `xmit_held` clears and `xmit_busy` and `lpm_req` rise together.
- R11: `lpm_req` is never high unless `xmit_busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xmit_wr | input | 1 | Software write of 1 to the transmit bit (pulse) |
| resume_wr | input | 1 | Software write of 1 to the resume bit (pulse) |
| token_rx | input | 1 | A reply token was received (strobe) |
| timeout_evt | input | 1 | Reply timeout occurred (strobe) |
| resume_dur | input | DUR_W | Programmed resume-duration field, in steps |
| us_tick | input | 1 | One-cycle microsecond tick |
| lpm_req | output | 1 | One-cycle request to send the transaction |
| xmit_busy | output | 1 | Transmit bit: attempt in progress |
| xmit_held | output | 1 | Transmit write waiting for resume to end |
| resume_drv | output | 1 | Resume signalling drive; also the resume bit |

## Verification
The assertions assume that `token_rx` and `timeout_evt` are single-cycle strobes that the packet engine produces only after a request. They also assume that software writes are one-cycle pulses. Under those assumptions, busy, held and drive are always in consistent states. The stimulus keeps every strobe to one cycle and drives all inputs on the falling edge. Token and timeout strobes are also applied while idle, because the design must ignore them there. The ordering assumption is relaxed only in that deliberate case.

// File: rtl/lpm_seq_pkg.sv
package lpm_seq_pkg;
  typedef enum logic [1:0] {
    XS_IDLE = 2'd0,
    XS_HELD = 2'd1,
    XS_WAIT = 2'd2
  } xmit_state_e;

  function automatic int unsigned width_of(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/lpm_step_prescaler.sv
module lpm_step_prescaler #(
  parameter int unsigned STEP_TICKS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  output logic step_last
);
  localparam int unsigned CW = lpm_seq_pkg::width_of(STEP_TICKS);
  localparam logic [CW-1:0] LAST = CW'(STEP_TICKS - 1);

  generate
    if (STEP_TICKS <= 1) begin : g_pass
      assign step_last = en;
    end else begin : g_count
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk) begin
        if (rst || clr) begin
          cnt_q <= '0;
        end else if (en) begin
          cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
      end
      assign step_last = en && (cnt_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/lpm_resume_timer.sv
module lpm_resume_timer #(
  parameter int unsigned DUR_W      = 4,
  parameter int unsigned STEP_TICKS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             resume_wr,
  input  logic [DUR_W-1:0] resume_dur,
  input  logic             us_tick,
  output logic             resume_drv,
  output logic             resume_done
);
  logic [DUR_W-1:0] dur_lat_q;
  logic [DUR_W-1:0] steps_q;
  logic             start;
  logic             step_last;

  assign start = resume_wr && !resume_drv;

  lpm_step_prescaler #(.STEP_TICKS(STEP_TICKS)) u_pre (
    .clk      (clk),
    .rst      (rst),
    .clr      (start),
    .en       (resume_drv && us_tick),
    .step_last(step_last)
  );

  assign resume_done = step_last && (steps_q == dur_lat_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      resume_drv <= 1'b0;
      dur_lat_q  <= '0;
      steps_q    <= '0;
    end else if (start) begin
      resume_drv <= 1'b1;
      dur_lat_q  <= resume_dur;
      steps_q    <= '0;
    end else if (resume_done) begin
      resume_drv <= 1'b0;
    end else if (step_last) begin
      steps_q <= steps_q + 1'b1;
    end
  end
endmodule

// File: rtl/lpm_xmit_ctrl.sv
module lpm_xmit_ctrl #(
  parameter int unsigned MAX_TIMEOUTS = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic xmit_wr,
  input  logic token_rx,
  input  logic timeout_evt,
  input  logic resume_active,
  input  logic resume_done,
  output logic lpm_req,
  output logic xmit_busy,
  output logic xmit_held
);
  import lpm_seq_pkg::*;
  localparam int unsigned TW = width_of(MAX_TIMEOUTS + 1);
  localparam logic [TW-1:0] TO_LAST = TW'(MAX_TIMEOUTS - 1);

  xmit_state_e   state_q, state_d;
  logic [TW-1:0] to_cnt_q, to_cnt_d;
  logic          launch, retry;

  always_comb begin
    state_d  = state_q;
    to_cnt_d = to_cnt_q;
    launch   = 1'b0;
    retry    = 1'b0;
    unique case (state_q)
      XS_IDLE: begin
        if (xmit_wr) begin
          if (!resume_active || resume_done) launch = 1'b1;
          else                               state_d = XS_HELD;
        end
      end
      XS_HELD: begin
        if (resume_done) launch = 1'b1;
      end
      XS_WAIT: begin
        if (token_rx) begin
          state_d  = XS_IDLE;
          to_cnt_d = '0;
        end else if (timeout_evt) begin
          if (to_cnt_q == TO_LAST) begin
            state_d  = XS_IDLE;
            to_cnt_d = '0;
          end else begin
            to_cnt_d = to_cnt_q + 1'b1;
            retry    = 1'b1;
          end
        end
      end
      default: state_d = XS_IDLE;
    endcase
    if (launch) begin
      state_d  = XS_WAIT;
      to_cnt_d = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= XS_IDLE;
      to_cnt_q  <= '0;
      lpm_req   <= 1'b0;
      xmit_busy <= 1'b0;
      xmit_held <= 1'b0;
    end else begin
      state_q   <= state_d;
      to_cnt_q  <= to_cnt_d;
      lpm_req   <= launch || retry;
      xmit_busy <= (state_d == XS_WAIT);
      xmit_held <= (state_d == XS_HELD);
    end
  end
endmodule

// File: rtl/lpm_host_seq.sv
module lpm_host_seq #(
  parameter int unsigned DUR_W        = 4,
  parameter int unsigned STEP_TICKS   = 4,
  parameter int unsigned MAX_TIMEOUTS = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             xmit_wr,
  input  logic             resume_wr,
  input  logic             token_rx,
  input  logic             timeout_evt,
  input  logic [DUR_W-1:0] resume_dur,
  input  logic             us_tick,
  output logic             lpm_req,
  output logic             xmit_busy,
  output logic             xmit_held,
  output logic             resume_drv
);
  logic resume_done;

  lpm_resume_timer #(.DUR_W(DUR_W), .STEP_TICKS(STEP_TICKS)) u_resume (
    .clk        (clk),
    .rst        (rst),
    .resume_wr  (resume_wr),
    .resume_dur (resume_dur),
    .us_tick    (us_tick),
    .resume_drv (resume_drv),
    .resume_done(resume_done)
  );

  lpm_xmit_ctrl #(.MAX_TIMEOUTS(MAX_TIMEOUTS)) u_xmit (
    .clk          (clk),
    .rst          (rst),
    .xmit_wr      (xmit_wr),
    .token_rx     (token_rx),
    .timeout_evt  (timeout_evt),
    .resume_active(resume_drv),
    .resume_done  (resume_done),
    .lpm_req      (lpm_req),
    .xmit_busy    (xmit_busy),
    .xmit_held    (xmit_held)
  );
endmodule

// File: rtl/lpm_host_seq_chk.sv
module lpm_host_seq_chk (
  input logic clk,
  input logic rst,
  input logic xmit_wr,
  input logic token_rx,
  input logic timeout_evt,
  input logic lpm_req,
  input logic xmit_busy,
  input logic xmit_held,
  input logic resume_drv
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!lpm_req && !xmit_busy && !xmit_held && !resume_drv));

  assert_launch_R2: assert property (@(posedge clk) disable iff (rst)
    (xmit_wr && !xmit_busy && !xmit_held && !resume_drv) |=> (xmit_busy && lpm_req));

  assert_timeout_outcome_R4: assert property (@(posedge clk) disable iff (rst)
    (xmit_busy && timeout_evt && !token_rx) |=> (xmit_busy == lpm_req));

  assert_token_clears_R5: assert property (@(posedge clk) disable iff (rst)
    (xmit_busy && token_rx) |=> (!xmit_busy && !lpm_req));

  assert_held_in_resume_R10: assert property (@(posedge clk) disable iff (rst)
    xmit_held |-> (resume_drv && !xmit_busy));

  assert_req_needs_busy_R11: assert property (@(posedge clk) disable iff (rst)
    lpm_req |-> xmit_busy);
endmodule

bind lpm_host_seq lpm_host_seq_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .xmit_wr    (xmit_wr),
  .token_rx   (token_rx),
  .timeout_evt(timeout_evt),
  .lpm_req    (lpm_req),
  .xmit_busy  (xmit_busy),
  .xmit_held  (xmit_held),
  .resume_drv (resume_drv)
);

// File: tb/lpm_host_seq_tb.sv
module lpm_host_seq_tb;
  localparam int DUR_W = 4;
  localparam int WATCHDOG_CYC = 200000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic xmit_wr = 1'b0, resume_wr = 1'b0, token_rx = 1'b0, timeout_evt = 1'b0;
  logic [DUR_W-1:0] resume_dur = '0;
  logic us_tick = 1'b0;
  logic lpm_req, xmit_busy, xmit_held, resume_drv;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  lpm_host_seq u_dut (
    .clk(clk), .rst(rst), .xmit_wr(xmit_wr), .resume_wr(resume_wr),
    .token_rx(token_rx), .timeout_evt(timeout_evt), .resume_dur(resume_dur),
    .us_tick(us_tick), .lpm_req(lpm_req), .xmit_busy(xmit_busy),
    .xmit_held(xmit_held), .resume_drv(resume_drv)
  );

  // {xmit_wr, token_rx, timeout_evt, exp_req, exp_busy}
  localparam int NV = 16;
  localparam logic [4:0] VEC [NV] = '{
    5'b100_11, // R2 launch
    5'b000_01, // R2 pulse lasts one cycle
    5'b001_11, // R3 first timeout retries
    5'b000_01,
    5'b001_11, // R3 second timeout retries
    5'b001_00, // R4 third timeout gives up
    5'b001_00, // R7 timeout while idle
    5'b010_00, // R7 token while idle
    5'b100_11, // R6 new launch
    5'b001_11, // R3 retry
    5'b010_00, // R5 token clears
    5'b100_11, // R6 launch again
    5'b100_01, // R7 write while busy ignored
    5'b001_11, // R6 count restarted: retry
    5'b001_11, // R6 second retry
    5'b011_00  // R5 token beats timeout
  };

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s got=%0d expected=%0d", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_inputs();
    xmit_wr = 0; resume_wr = 0; token_rx = 0; timeout_evt = 0;
  endtask

  initial begin
    int n;
    @(negedge clk);
    tick(); tick();
    check("R1 req in reset", lpm_req, 0);
    check("R1 busy in reset", xmit_busy, 0);
    check("R1 drv in reset", resume_drv, 0);
    check("R1 held in reset", xmit_held, 0);
    rst = 0;

    for (int i = 0; i < NV; i++) begin
      {xmit_wr, token_rx, timeout_evt} = VEC[i][4:2];
      tick();
      clear_inputs();
      check($sformatf("R2-R7 vec%0d req", i), lpm_req, VEC[i][1]);
      check($sformatf("R2-R7 vec%0d busy", i), xmit_busy, VEC[i][0]);
    end

    // R8: duration 2 -> 12 ticked cycles; R9 field change and rewrite ignored
    resume_dur = 4'd2; us_tick = 1; resume_wr = 1;
    tick(); clear_inputs();
    check("R8 drive starts", resume_drv, 1);
    resume_dur = 4'd0;
    n = 1;
    for (int k = 0; k < 40 && resume_drv; k++) begin
      resume_wr = (k == 3);
      tick(); clear_inputs();
      if (resume_drv) n++;
    end
    check("R8 R9 drive length", n, 12);
    check("R8 self clear", resume_drv, 0);

    // R8: no progress without ticks
    resume_dur = 4'd0; us_tick = 0; resume_wr = 1;
    tick(); clear_inputs();
    repeat (10) tick();
    check("R8 stalls without tick", resume_drv, 1);
    // R10: write during resume is held
    xmit_wr = 1;
    tick(); clear_inputs();
    check("R10 held set", xmit_held, 1);
    check("R10 busy stays low", xmit_busy, 0);
    us_tick = 1;
    n = 0;
    for (int k = 0; k < 40 && resume_drv; k++) begin
      tick();
      if (resume_drv) begin
        n++;
        if (xmit_busy) check("R10 busy during resume", xmit_busy, 0);
      end
    end
    check("R8 dur0 length", n + 1, 4);
    check("R10 launch on end busy", xmit_busy, 1);
    check("R10 launch on end req", lpm_req, 1);
    check("R10 held cleared", xmit_held, 0);
    us_tick = 0;

    // R1: reset mid-run
    resume_wr = 1;
    tick(); clear_inputs();
    rst = 1;
    tick();
    check("R1 busy after reset", xmit_busy, 0);
    check("R1 drv after reset", resume_drv, 0);
    check("R1 req after reset", lpm_req, 0);
    rst = 0;
    // R6: after reset the count is zero: two retries then give up
    xmit_wr = 1; tick(); clear_inputs();
    timeout_evt = 1; tick(); clear_inputs();
    check("R6 retry after reset", lpm_req, 1);
    timeout_evt = 1; tick(); clear_inputs();
    check("R3 second retry", xmit_busy, 1);
    timeout_evt = 1; tick(); clear_inputs();
    check("R4 give up", xmit_busy, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired got=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule